// File: doc/BRIEF.md
# Packed Field Register Bank

This block is a bus-attached register slave. A processor sends requests over a valid/ready channel. Each request carries an address, a read/write flag, a 64-bit write beat and a byte mask. The bank checks that the address falls inside its 4 KiB window and selects the 8-byte beat the address points to. It then reads or updates the fields packed into that beat. Every request gets exactly one response on a second valid/ready channel, and responses come back in request order.

Fields of different widths share beats. They are packed from the least significant bit upward, so the first field at an offset takes the lowest lanes. Every field at one offset is read and written by the same access. One beat is read-only: it holds a fixed identification byte and a byte that mirrors a live status input. An optional request queue of `QDEPTH` entries sits in front of the access stage. A depth of 0 removes the queue, and `req_ready` then follows the response slot combinationally.

Back-pressure rules:
- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- A response transfers on a clock edge where `rsp_valid` and `rsp_ready` are both high.
- While `rsp_valid` is high and `rsp_ready` is low, the response and all its fields stay unchanged.
- When the queue and the response slot are full, `req_ready` goes low.

Top module: `pkreg_bank`

## Requirements
- R1: After reset, every writable field reads as zero, `rsp_valid` is low and `req_ready` is high.
- R2: A request is inside the window when `(addr & ~0xFFF) == 0x10019000`. A request outside the window changes no field, and its response has `rsp_oow`=1 and `rsp_rdata`=0.
- R3: Beat 0 (offset 0x00) holds one 64-bit register on data bits 63:0.
- R4: Beat 1 (offset 0x08) packs the following fields, lowest first:
  - a 32-bit register on lanes 0-3 (bits 31:0);
  - a 16-bit register on lanes 4-5 (offset 0x0C, bits 47:32);
  - two 4-bit fields on lane 6 (offset 0x0E). The first field is on bits 51:48 and the second on bits 55:52, so writing 0xAB to that lane stores 0xB in the first and 0xA in the second. Both nibbles update in the same access.
- R5: Mask bit i enables write data byte i (bits 8i+7:8i). A byte whose mask bit is 0 keeps its old value.
- R6: Beat 2 (offset 0x10) is read-only. Lane 0 returns the constant `RO_CONST` (default 0xD5). Lane 1 returns `live_sts` as it is at the access. Writes to beat 2 have no effect.
- R7: Unmapped bytes inside the window read as zero. These are lane 7 of beat 1, lanes 2-7 of beat 2, and every beat from 3 upward. Writes to them have no effect.
- R8: Each accepted request produces exactly one response, in request order. A read returns the beat as it was before that access. A write response carries `rsp_rdata`=0.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_oow` stay stable.
- R10: With `QDEPTH`=N>0, at most N+1 requests are outstanding. When N+1 are outstanding, `req_ready` is low. With N=0, `req_ready` = !`rsp_valid` || `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank can take a request |
| req_addr | input | 32 | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write beat |
| req_mask | input | 8 | Byte write enables |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 64 | Read beat, zero for writes and out-of-window requests |
| rsp_oow | output | 1 | Request address was outside the window |
| live_sts | input | 8 | Live status byte shown in beat 2 |

## Verification
The bound assertions check the following on every cycle:
- a stalled response stays stable;
- an out-of-window response carries zero data;
- no response appears without an outstanding request;
- the outstanding count stays within the queue bound, and a full bank refuses requests.

Only the bench's scenarios can show the rest:
- field placement within the beats;
- byte-masked merging;
- the nibble order at offset 0x0E;
- writes ignored by the read-only and unmapped bytes;
- the live byte;
- response ordering across a stall.

// File: rtl/pkreg_pkg.sv
package pkreg_pkg;
  localparam int DATA_W = 64;
  localparam int BYTES  = DATA_W / 8;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int LANE_W = $clog2(BYTES);
  localparam int BEAT_W = OFF_W - LANE_W;

  // beat indices within the window
  localparam logic [BEAT_W-1:0] BEAT_WIDE = BEAT_W'(0);
  localparam logic [BEAT_W-1:0] BEAT_PACK = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] BEAT_RO   = BEAT_W'(2);

  // lane positions inside the packed beat
  localparam int MID_LANE  = 0;
  localparam int MID_BYTES = 4;
  localparam int HALF_LANE = 4;
  localparam int HALF_BYTES = 2;
  localparam int NIB_LANE  = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DATA_W-1:0] wdata;
    logic [BYTES-1:0]  mask;
  } req_t;
endpackage

// File: rtl/pkreg_reqq.sv
module pkreg_reqq
  import pkreg_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  req_t in_req,
  output logic out_valid,
  input  logic out_ready,
  output req_t out_req
);
  if (DEPTH == 0) begin : g_pass
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_req   = in_req;
  end else begin : g_fifo
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    req_t          slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          push, pop;

    assign in_ready  = (fill != CW'(DEPTH));
    assign out_valid = (fill != '0);
    assign out_req   = slots[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        fill   <= '0;
      end else begin
        if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        if (push && !pop)      fill <= fill + 1'b1;
        else if (pop && !push) fill <= fill - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= in_req;
    end
  end
endmodule

// File: rtl/pkreg_fields.sv
module pkreg_fields
  import pkreg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE     = 32'h1001_9000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'h0000_0FFF,
  parameter logic [7:0]        RO_CONST = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  req_t              acc,
  input  logic [7:0]        live_sts,
  output logic [DATA_W-1:0] rd_data,
  output logic              in_win
);
  logic [BEAT_W-1:0] beat;
  logic              wr_go;

  assign in_win = ((acc.addr & ~WIN_MASK) == BASE);
  assign beat   = acc.addr[OFF_W-1:LANE_W];
  assign wr_go  = acc_en && acc.wr && in_win;

  // full-width register, one byte lane per generated slice
  logic [7:0]        wide_b [BYTES];
  logic [DATA_W-1:0] wide_v;

  for (genvar b = 0; b < BYTES; b++) begin : g_wide
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wide_b[b] <= '0;
      else if (wr_go && beat == BEAT_WIDE && acc.mask[b])
        wide_b[b] <= acc.wdata[8*b +: 8];
    end
    assign wide_v[8*b +: 8] = wide_b[b];
  end

  // packed beat: 32-bit, 16-bit, then two nibbles sharing one lane
  logic [8*MID_BYTES-1:0]  mid_q;
  logic [8*HALF_BYTES-1:0] half_q;
  logic [3:0]              nib_lo_q, nib_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q    <= '0;
      half_q   <= '0;
      nib_lo_q <= '0;
      nib_hi_q <= '0;
    end else if (wr_go && beat == BEAT_PACK) begin
      for (int b = 0; b < MID_BYTES; b++)
        if (acc.mask[MID_LANE+b])
          mid_q[8*b +: 8] <= acc.wdata[8*(MID_LANE+b) +: 8];
      for (int b = 0; b < HALF_BYTES; b++)
        if (acc.mask[HALF_LANE+b])
          half_q[8*b +: 8] <= acc.wdata[8*(HALF_LANE+b) +: 8];
      if (acc.mask[NIB_LANE]) begin
        nib_lo_q <= acc.wdata[8*NIB_LANE +: 4];
        nib_hi_q <= acc.wdata[8*NIB_LANE+4 +: 4];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (in_win) begin
      case (beat)
        BEAT_WIDE: rd_data = wide_v;
        BEAT_PACK: begin
          rd_data[8*MID_LANE +: 8*MID_BYTES]   = mid_q;
          rd_data[8*HALF_LANE +: 8*HALF_BYTES] = half_q;
          rd_data[8*NIB_LANE +: 8]             = {nib_hi_q, nib_lo_q};
        end
        BEAT_RO: begin
          rd_data[7:0]  = RO_CONST;
          rd_data[15:8] = live_sts;
        end
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pkreg_bank.sv
module pkreg_bank
  import pkreg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE     = 32'h1001_9000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'h0000_0FFF,
  parameter int                QDEPTH   = 2,
  parameter logic [7:0]        RO_CONST = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BYTES-1:0]  req_mask,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_oow,
  input  logic [7:0]        live_sts
);
  req_t              in_req, head;
  logic              head_valid, head_ready, exec_go, win_hit;
  logic [DATA_W-1:0] beat_data;

  assign in_req = '{addr: req_addr, wr: req_write, wdata: req_wdata, mask: req_mask};

  pkreg_reqq #(.DEPTH(QDEPTH)) u_reqq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_req   (in_req),
    .out_valid(head_valid),
    .out_ready(head_ready),
    .out_req  (head)
  );

  // response slot frees when empty or being drained this edge
  assign head_ready = !rsp_valid || rsp_ready;
  assign exec_go    = head_valid && head_ready;

  pkreg_fields #(.BASE(BASE), .WIN_MASK(WIN_MASK), .RO_CONST(RO_CONST)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (exec_go),
    .acc     (head),
    .live_sts(live_sts),
    .rd_data (beat_data),
    .in_win  (win_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_oow   <= 1'b0;
    end else if (exec_go) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= head.wr ? '0 : beat_data;
      rsp_oow   <= !win_hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkreg_bank_chk.sv
module pkreg_bank_chk #(
  parameter int QDEPTH = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_rdata,
  input logic        rsp_oow
);
  logic [7:0] outst;
  logic       req_fire, rsp_fire;

  assign req_fire = req_valid && req_ready;
  assign rsp_fire = rsp_valid && rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else        outst <= outst + {7'd0, req_fire} - {7'd0, rsp_fire};
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_oow));

  p_oow_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_oow |-> rsp_rdata == '0);

  p_no_orphan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> outst != '0);

  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outst) <= QDEPTH + 1);

  p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(outst) == QDEPTH + 1) && !rsp_ready |-> !req_ready);
endmodule

bind pkreg_bank pkreg_bank_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .rsp_oow  (rsp_oow)
);

// File: tb/pkreg_bank_tb.sv
module pkreg_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] B = 32'h1001_9000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_mask = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic        rsp_oow;
  logic [7:0]  live_sts = 8'h5A;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] d;
    logic        o;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkreg_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_oow(rsp_oow), .live_sts(live_sts)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input logic [63:0] d,
                       input logic [7:0] m, input logic [63:0] ed, input logic eo, input string tag);
    exp_t e;
    e.d = ed; e.o = eo; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_addr = a; req_write = w; req_wdata = d; req_mask = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [63:0] ed, input logic eo, input string tag);
    issue(a, 1'b0, 64'h0, 8'h00, ed, eo, tag);
  endtask

  task automatic wr(input logic [31:0] a, input logic [63:0] d, input logic [7:0] m, input logic eo, input string tag);
    issue(a, 1'b1, d, m, 64'h0, eo, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_rdata !== e.d || rsp_oow !== e.o) begin
          errors++;
          $display("FAIL %s: actual=%h/oow=%b expected=%h/oow=%b", e.tag, rsp_rdata, rsp_oow, e.d, e.o);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'h1);

    // R1: reset values
    rd(B + 32'h000, 64'h0, 1'b0, "R1 wide reset");
    rd(B + 32'h008, 64'h0, 1'b0, "R1 packed reset");

    // R3: full 64-bit register
    wr(B + 32'h000, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0, "R3 write");
    rd(B + 32'h000, 64'h0123_4567_89AB_CDEF, 1'b0, "R3 readback");

    // R5: byte mask, lanes 0 and 7 only
    wr(B + 32'h000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, 1'b0, "R5 masked write");
    rd(B + 32'h000, 64'hFF23_4567_89AB_CDFF, 1'b0, "R5 merge");

    // R4: packed beat, nibble order at 0x0E
    wr(B + 32'h00E, 64'h00AB_0000_0000_0000, 8'h40, 1'b0, "R4 nibbles");
    rd(B + 32'h008, 64'h00AB_0000_0000_0000, 1'b0, "R4 nibble order");
    wr(B + 32'h008, 64'h0000_0000_1122_3344, 8'h0F, 1'b0, "R4 mid");
    wr(B + 32'h00C, 64'h0000_BEEF_0000_0000, 8'h30, 1'b0, "R4 half");
    rd(B + 32'h00C, 64'h00AB_BEEF_1122_3344, 1'b0, "R4 packed beat");
    // R5: partial write of the 16-bit register keeps its other byte
    wr(B + 32'h00C, 64'h0000_0700_0000_0000, 8'h20, 1'b0, "R5 half hi byte");
    rd(B + 32'h008, 64'h00AB_07EF_1122_3344, 1'b0, "R5 half merge");

    // R7: unmapped lane 7 of packed beat ignores writes
    wr(B + 32'h008, 64'hFF00_0000_0000_0000, 8'h80, 1'b0, "R7 lane7 write");
    rd(B + 32'h008, 64'h00AB_07EF_1122_3344, 1'b0, "R7 lane7 reads zero");

    // R6: read-only constant and live byte, writes ignored
    rd(B + 32'h010, 64'h0000_0000_0000_5AD5, 1'b0, "R6 constant and live");
    wr(B + 32'h010, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, "R6 write");
    drain();
    live_sts = 8'hC3;
    rd(B + 32'h010, 64'h0000_0000_0000_C3D5, 1'b0, "R6 after write, new live");

    // R7: unmapped beats
    wr(B + 32'h018, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, "R7 beat3 write");
    rd(B + 32'h018, 64'h0, 1'b0, "R7 beat3");
    rd(B + 32'hFF8, 64'h0, 1'b0, "R7 top beat");

    // R2: outside the window
    wr(32'h1001_A000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, "R2 write above");
    wr(32'h1001_8000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, "R2 write below");
    rd(32'h0001_9000, 64'h0, 1'b1, "R2 read outside");
    rd(B + 32'h000, 64'hFF23_4567_89AB_CDFF, 1'b0, "R2 wide untouched");
    drain();

    // R9/R10: stall the response channel, fill queue
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(B + 32'h000, 64'hFF23_4567_89AB_CDFF, 1'b0, "R8 order first");
    rd(B + 32'h008, 64'h00AB_07EF_1122_3344, 1'b0, "R8 order second");
    rd(B + 32'h010, 64'h0000_0000_0000_C3D5, 1'b0, "R8 order third");
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 full bank refuses", 64'(req_ready), 64'h0);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R9 valid held", 64'(rsp_valid), 64'h1);
    chk(rsp_rdata == 64'hFF23_4567_89AB_CDFF, "R9 data held", rsp_rdata, 64'hFF23_4567_89AB_CDFF);
    rsp_ready = 1'b1;
    drain();

    // R8: back-to-back mix, read sees value before its own access
    wr(B + 32'h000, 64'h0000_0000_0000_0042, 8'h01, 1'b0, "R8 mix write");
    rd(B + 32'h000, 64'hFF23_4567_89AB_CD42, 1'b0, "R8 mix read");
    rd(32'h2000_0000, 64'h0, 1'b1, "R8 mix outside");
    drain();
    chk(sb.size() == 0, "R8 all responses seen", 64'(sb.size()), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule